// File: doc/BRIEF.md
# Two-Write Host Command Port Decoder

This block sits between a 16-bit host write path and the internal machines of a larger controller. The host sends one 32-bit command as two consecutive 16-bit writes, each qualified by the port-select strobe. The first write carries the low half and the second carries the high half. Between the two writes the block freezes the internal machines through a hold output. When the second write arrives, the block releases the hold and issues a one-cycle strobe. The strobe carries the decoded function and the 28-bit address that was packed into bits 31..4 of the command. Bits 3..0 hold the function code.

Four functions exist: a software reset, a self-test request, loading an alternative configuration-pointer address, and loading a dump-area pointer together with a dump request. The block keeps the configuration pointer that is currently in force. It also watches the channel-attention input after a software reset. A channel attention that arrives too soon is flagged as rejected. A later one is passed on as the start of a new initialization.

Top module: `hostcmd_port`

## Requirements
- R1: After hardware reset, `hold_o`, `cmd_stb`, `ca_reject` and `ca_init` are low, and `cfg_ptr` equals the parameter `DEF_CFG_PTR`.
- R2: A `port_wr` cycle while the block expects a first write stores `wr_data` as command bits 15..0. `hold_o` goes high in the following cycle and stays high through idle cycles until the second write.
- R3: The next `port_wr` cycle supplies command bits 31..16. With a valid code, `cmd_stb` is high for exactly one cycle, in the cycle after that write. In that same cycle `hold_o` is low and `cmd_addr` equals command bits 31..4.
- R4: Command bits 3..0 select the function. 0000 is software reset, 0001 is self-test, 0010 is alternative configuration pointer, and 0011 is dump pointer with dump. `cmd_func` presents the code's low two bits: 0, 1, 2 and 3 respectively.
- R5: A code of 0100 or above is ignored. `hold_o` drops after the second write, `cmd_stb` stays low, and `cfg_ptr` is unchanged.
- R6: An alternative-configuration command (code 0010) loads `cfg_ptr` with command bits 31..4, visible in the strobe cycle. The value survives all other commands, including a software reset. Only a hardware reset restores `DEF_CFG_PTR`.
- R7: A software-reset command (code 0000) strobes with `cmd_func` = 0 whatever bits 31..4 hold.
- R8: A software-reset strobe opens a guard window that starts in the strobe cycle. The window lasts for at least `SYS_GAP` system clocks and until `SER_GAP` `ser_tick` pulses have been seen. A `chan_att` cycle inside the window gives a one-cycle `ca_reject` in the next cycle and no `ca_init`.
- R9: A `chan_att` cycle outside the guard window gives a one-cycle `ca_init` in the next cycle and no `ca_reject`.
- R10: Once a command completes (any code, software reset included), the next `port_wr` is again treated as a first write.
- R11: A hardware reset between the two writes discards the pending half. The next `port_wr` is treated as a first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| port_wr | input | 1 | Port-select qualified write strobe, one cycle per write |
| wr_data | input | HALF_W | Write data half-word |
| ser_tick | input | 1 | One pulse per serial clock, synchronous to `clk` |
| chan_att | input | 1 | Channel attention from the host |
| hold_o | output | 1 | Freezes the internal machines between the two writes |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_func | output | 2 | Function: 0 reset, 1 self-test, 2 alt config pointer, 3 dump |
| cmd_addr | output | 2*HALF_W-4 | Command bits 31..4 (16-byte aligned address) |
| cfg_ptr | output | 2*HALF_W-4 | Configuration pointer in force |
| ca_reject | output | 1 | Channel attention fell inside the post-reset guard window |
| ca_init | output | 1 | Accepted channel attention, starts initialization |

## Verification
The bench builds the block with `HALF_W` = 16, `SYS_GAP` = 10 and `SER_GAP` = 5. It sets `DEF_CFG_PTR` to 0x00ABCDE, a value that no command in the tests writes, so a restore after hardware reset is visible. With these small gaps, both edges of the guard window fall within about a dozen cycles. The bench hits the last rejected and first accepted channel-attention cycles directly. A separate run stretches the window through its serial-tick condition alone.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;

  typedef enum logic [1:0] {
    FN_PRESET   = 2'd0,
    FN_SELFTEST = 2'd1,
    FN_ALTCFG   = 2'd2,
    FN_DUMP     = 2'd3
  } port_fn_e;

  // A code is usable only when its upper two bits are clear.
  function automatic logic code_valid(input logic [3:0] nib);
    return (nib[3:2] == 2'b00);
  endfunction

  function automatic port_fn_e code_to_fn(input logic [3:0] nib);
    return port_fn_e'(nib[1:0]);
  endfunction

  // Saturating increment used by the guard counters.
  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic en,
                                         input logic [7:0] lim);
    if (!en || v >= lim) return v;
    return v + 8'd1;
  endfunction

endpackage

// File: rtl/hostcmd_pair.sv
module hostcmd_pair #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_wr,
  input  logic [HALF_W-1:0]   wr_data,
  output logic                hold_o,
  output logic                expect_second,
  output logic                second_evt,
  output logic [2*HALF_W-1:0] word_o
);
  logic [HALF_W-1:0] low_q;
  logic              phase_q;
  logic              hold_q;

  assign expect_second = phase_q;
  assign second_evt    = port_wr & phase_q;
  assign word_o        = {wr_data, low_q};
  assign hold_o        = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hold_q  <= 1'b0;
      low_q   <= '0;
    end else if (port_wr) begin
      if (!phase_q) begin
        low_q   <= wr_data;
        phase_q <= 1'b1;
        hold_q  <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        hold_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hostcmd_decode.sv
module hostcmd_decode
  import hostcmd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter logic [WORD_W-5:0] DEF_CFG_PTR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] word,
  output logic              cmd_stb,
  output port_fn_e          cmd_func,
  output logic [WORD_W-5:0] cmd_addr,
  output logic [WORD_W-5:0] cfg_ptr,
  output logic              preset_evt,
  output logic              bad_evt
);
  logic     ok_w;
  port_fn_e fn_w;

  assign ok_w       = code_valid(word[3:0]);
  assign fn_w       = code_to_fn(word[3:0]);
  assign preset_evt = fire & ok_w & (fn_w == FN_PRESET);
  assign bad_evt    = fire & ~ok_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_stb  <= 1'b0;
      cmd_func <= FN_PRESET;
      cmd_addr <= '0;
      cfg_ptr  <= DEF_CFG_PTR;
    end else begin
      cmd_stb <= fire & ok_w;
      if (fire & ok_w) begin
        cmd_func <= fn_w;
        cmd_addr <= word[WORD_W-1:4];
        if (fn_w == FN_ALTCFG) cfg_ptr <= word[WORD_W-1:4];
      end
    end
  end
endmodule

// File: rtl/hostcmd_ca_guard.sv
module hostcmd_ca_guard
  import hostcmd_pkg::*;
#(
  parameter int SYS_GAP = 10,
  parameter int SER_GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ser_tick,
  input  logic chan_att,
  output logic win_o,
  output logic ca_reject,
  output logic ca_init
);
  localparam logic [7:0] SYS_LIM = 8'(SYS_GAP);
  localparam logic [7:0] SER_LIM = 8'(SER_GAP);

  logic [7:0] sys_q, ser_q, sys_nx, ser_nx;
  logic       win_q;

  assign sys_nx = sat_inc(sys_q, 1'b1, SYS_LIM);
  assign ser_nx = sat_inc(ser_q, ser_tick, SER_LIM);
  assign win_o  = win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q     <= 1'b0;
      sys_q     <= '0;
      ser_q     <= '0;
      ca_reject <= 1'b0;
      ca_init   <= 1'b0;
    end else begin
      ca_reject <= chan_att & win_q;
      ca_init   <= chan_att & ~win_q;
      if (arm) begin
        win_q <= 1'b1;
        sys_q <= '0;
        ser_q <= '0;
      end else if (win_q) begin
        sys_q <= sys_nx;
        ser_q <= ser_nx;
        win_q <= !((sys_nx >= SYS_LIM) && (ser_nx >= SER_LIM));
      end
    end
  end
endmodule

// File: rtl/hostcmd_port.sv
module hostcmd_port
  import hostcmd_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int SYS_GAP = 10,
  parameter int SER_GAP = 5,
  parameter logic [2*HALF_W-5:0] DEF_CFG_PTR = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_wr,
  input  logic [HALF_W-1:0]   wr_data,
  input  logic                ser_tick,
  input  logic                chan_att,
  output logic                hold_o,
  output logic                cmd_stb,
  output logic [1:0]          cmd_func,
  output logic [2*HALF_W-5:0] cmd_addr,
  output logic [2*HALF_W-5:0] cfg_ptr,
  output logic                ca_reject,
  output logic                ca_init
);
  localparam int WORD_W = 2 * HALF_W;

  logic              expect_second;
  logic              second_evt;
  logic [WORD_W-1:0] word_w;
  logic              preset_evt;
  logic              bad_evt;
  logic              win;
  port_fn_e          fn_w;

  hostcmd_pair #(.HALF_W(HALF_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .wr_data(wr_data),
    .hold_o(hold_o), .expect_second(expect_second),
    .second_evt(second_evt), .word_o(word_w)
  );

  hostcmd_decode #(.WORD_W(WORD_W), .DEF_CFG_PTR(DEF_CFG_PTR)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(second_evt), .word(word_w),
    .cmd_stb(cmd_stb), .cmd_func(fn_w), .cmd_addr(cmd_addr),
    .cfg_ptr(cfg_ptr), .preset_evt(preset_evt), .bad_evt(bad_evt)
  );

  hostcmd_ca_guard #(.SYS_GAP(SYS_GAP), .SER_GAP(SER_GAP)) u_guard (
    .clk(clk), .rst_n(rst_n), .arm(preset_evt), .ser_tick(ser_tick),
    .chan_att(chan_att), .win_o(win), .ca_reject(ca_reject),
    .ca_init(ca_init)
  );

  assign cmd_func = fn_w;
endmodule

// File: rtl/hostcmd_port_chk.sv
module hostcmd_port_chk #(
  parameter int AW = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_wr,
  input logic          expect_second,
  input logic          hold_o,
  input logic          cmd_stb,
  input logic [1:0]    cmd_func,
  input logic [AW-1:0] cfg_ptr,
  input logic          bad_evt,
  input logic          win,
  input logic          ca_reject,
  input logic          ca_init
);
  AST_HOLD_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !expect_second) |=> hold_o); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R3
  AST_STB_RELEASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (!hold_o && $past(hold_o))); // R3
  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (!cmd_stb && !hold_o)); // R5
  AST_CFG_ONLY_BY_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_ptr) |-> (cmd_stb && cmd_func == 2'd2)); // R6
  AST_CA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ca_reject && ca_init)); // R9
  AST_REJECT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ca_reject |-> $past(win)); // R8
endmodule

bind hostcmd_port hostcmd_port_chk #(.AW(2*HALF_W-4)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .expect_second(expect_second),
  .hold_o(hold_o), .cmd_stb(cmd_stb), .cmd_func(cmd_func), .cfg_ptr(cfg_ptr),
  .bad_evt(bad_evt), .win(win), .ca_reject(ca_reject), .ca_init(ca_init)
);

// File: tb/sim_hostcmd_port.sv
`timescale 1ns/1ps
module sim_hostcmd_port;
  localparam int HW = 16;
  localparam int AW = 2*HW-4;
  localparam logic [AW-1:0] DEFP = 28'h00ABCDE;

  logic clk = 1'b0, rst_n = 1'b0, port_wr = 1'b0, ser_tick = 1'b0, chan_att = 1'b0;
  logic [HW-1:0] wr_data = '0;
  logic hold_o, cmd_stb, ca_reject, ca_init;
  logic [1:0] cmd_func;
  logic [AW-1:0] cmd_addr, cfg_ptr;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hostcmd_port #(.HALF_W(HW), .SYS_GAP(10), .SER_GAP(5), .DEF_CFG_PTR(DEFP)) u0 (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .wr_data(wr_data),
    .ser_tick(ser_tick), .chan_att(chan_att), .hold_o(hold_o), .cmd_stb(cmd_stb),
    .cmd_func(cmd_func), .cmd_addr(cmd_addr), .cfg_ptr(cfg_ptr),
    .ca_reject(ca_reject), .ca_init(ca_init)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [HW-1:0] d);
    @(negedge clk); port_wr = 1'b1; wr_data = d;
    @(negedge clk); port_wr = 1'b0; wr_data = '0;
  endtask

  // Sends one command; returns at the negedge of the strobe cycle.
  task automatic send(input logic [3:0] nib, input logic [AW-1:0] a);
    wr({a[11:0], nib});
    wr(a[AW-1:12]);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    hw_reset();
    chk("R1 hold", hold_o, 0);
    chk("R1 stb", cmd_stb, 0);
    chk("R1 cfg", cfg_ptr, DEFP);
    chk("R1 ca", {ca_reject, ca_init}, 0);
  endtask

  task automatic t_pair_hold();
    wr(16'h1231);
    chk("R2 hold after first", hold_o, 1);
    chk("R2 no stb yet", cmd_stb, 0);
    repeat (3) @(negedge clk);
    chk("R2 hold kept idle", hold_o, 1);
    wr(16'h0456);
    chk("R3 stb", cmd_stb, 1);
    chk("R3 hold low", hold_o, 0);
    chk("R4 selftest func", cmd_func, 1);
    chk("R3 addr", cmd_addr, 28'h0456123);
  endtask

  task automatic t_cmd(input logic [3:0] nib, input logic [AW-1:0] a);
    logic [AW-1:0] cfg_before;
    cfg_before = cfg_ptr;
    send(nib, a);
    chk("R3 stb", cmd_stb, 1);
    chk("R4 func", cmd_func, {30'd0, nib[1:0]});
    chk("R3 addr", cmd_addr, a);
    chk("R6 cfg", cfg_ptr, (nib == 4'd2) ? a : cfg_before);
    @(negedge clk);
    chk("R3 single cycle", cmd_stb, 0);
  endtask

  task automatic t_bad_code(input logic [3:0] nib);
    logic [AW-1:0] cfg_before;
    cfg_before = cfg_ptr;
    send(nib, 28'h7777777);
    chk("R5 no stb", cmd_stb, 0);
    chk("R5 hold released", hold_o, 0);
    @(negedge clk);
    chk("R5 no stb later", cmd_stb, 0);
    chk("R5 cfg kept", cfg_ptr, cfg_before);
  endtask

  task automatic t_preset_and_window();
    logic [AW-1:0] cfg_before;
    cfg_before = cfg_ptr;
    send(4'd0, 28'hFEDCBA9);
    chk("R7 stb", cmd_stb, 1);
    chk("R7 func", cmd_func, 0);
    chk("R6 cfg survives preset", cfg_ptr, cfg_before);
    ser_tick = 1'b1;
    repeat (5) @(negedge clk);
    ser_tick = 1'b0;
    repeat (4) @(negedge clk);
    chan_att = 1'b1;
    @(negedge clk);
    chk("R8 last window cycle rejected", ca_reject, 1);
    chk("R8 no init", ca_init, 0);
    @(negedge clk);
    chan_att = 1'b0;
    chk("R9 first free cycle init", ca_init, 1);
    chk("R9 no reject", ca_reject, 0);
    // R10: pairing starts fresh after the reset command
    t_cmd(4'd3, 28'h0000420);
  endtask

  task automatic t_serial_window();
    send(4'd0, 28'h0);
    repeat (12) @(negedge clk);
    chan_att = 1'b1;
    @(negedge clk);
    chan_att = 1'b0;
    chk("R8 serial gap keeps window", ca_reject, 1);
    ser_tick = 1'b1;
    repeat (5) @(negedge clk);
    ser_tick = 1'b0;
    chan_att = 1'b1;
    @(negedge clk);
    chan_att = 1'b0;
    chk("R9 after serial ticks", ca_init, 1);
    chk("R9 no reject after serial", ca_reject, 0);
  endtask

  task automatic t_reset_mid_pair();
    wr(16'hAAA2);
    hw_reset();
    chk("R11 hold cleared", hold_o, 0);
    chk("R6 default restored", cfg_ptr, DEFP);
    send(4'd2, 28'h0BEEF01);
    chk("R11 fresh pair strobes", cmd_stb, 1);
    chk("R11 addr", cmd_addr, 28'h0BEEF01);
  endtask

  initial begin
    t_reset_state();
    t_pair_hold();
    t_cmd(4'd2, 28'h1234567);
    t_cmd(4'd1, 28'h0000010);
    t_cmd(4'd3, 28'hFFFFFFF);
    t_bad_code(4'h4);
    t_bad_code(4'hC);
    t_cmd(4'd1, 28'h0000001);
    t_preset_and_window();
    t_serial_window();
    t_reset_mid_pair();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule